// File: doc/BRIEF.md
# Vectored Interrupt Controller

This unit sits beside the execute stage of a small 16-bit core and decides, cycle by cycle, whether the core must leave its instruction stream for an interrupt handler or come back from one. It keeps a file of sixteen 16-bit handler addresses. Dedicated instructions fill and read that file through a single index port.

Requests come from three places:
- three trap lines raised by the execute stage: an illegal or error opcode, a divide by zero, and a bad memory access;
- level-sensitive lines from peripherals, numbered 3 to 15;
- a software-interrupt instruction that carries a 4-bit handler number.

When an entry is allowed, the unit redirects the program counter to the selected handler and tells the core to flush. It signals the core to save its flags and clear the global enable bit. At the next edge it captures the return address and the flag word in its own registers.

A return-from-interrupt instruction is also handled here. It redirects to the saved return address and asks the core to reload its flags from the shadow copy. Both saved registers can also be written directly by system instructions. The surrounding pipeline is not part of this block.

Top module: `irq_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, all handler addresses, `ira_q` and `shfl_q` become 0. During reset `redirect`, `flag_save` and `flag_restore` are 0.
- R2: When `vec_we` is high at an edge, handler entry `vec_idx` takes `vec_wdata`. `vec_rdata` always shows the entry selected by `vec_idx`.
- R3: No entry and no return takes place unless `ex_valid` is 1 and `unit_busy` is 0 in that cycle.
- R4: Peripheral line `dev_req[k]` requests interrupt k+3 and is honoured only while `gie` is 1. Trap line `trap_req[k]` requests interrupt k (0 illegal/error, 1 divide by zero, 2 bad access) whatever `gie` is.
- R5: Among pending hardware requests the lowest interrupt number is taken. A software interrupt (`swi_valid`, number `swi_num`) is taken, whatever `gie` is, only when no hardware request is pending.
- R6: On entry, in the same cycle:
  - `redirect` and `flag_save` are 1;
  - `taken_num` is the interrupt number;
  - `redirect_pc` is the handler address stored for that number before any write in that cycle.
  When there is neither an entry nor a return, `redirect_pc` and `taken_num` are 0.
- R7: On entry `ira_q` takes, at the next edge, `pc_cur` for interrupts 3 to 15 from peripherals. It takes `pc_next` for traps 0 to 2 and for software interrupts.
- R8: On entry `shfl_q` takes `flags_in` at the next edge.
- R9: When `reti` is 1, the cycle is eligible (R3) and there is no entry, then:
  - `redirect` and `flag_restore` are 1;
  - `redirect_pc` equals `ira_q`.
  An entry in the same cycle takes precedence over the return.
- R10: `ira_we` and `shfl_we` load `sys_wdata` into `ira_q` and `shfl_q`. An entry in the same cycle overrides these writes.
- R11: Peripheral requests are not latched. A line held high is taken again in every eligible cycle. A line dropped before an eligible cycle leaves nothing pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 3 | Trap requests for interrupts 0..2 |
| dev_req | input | 13 | Level peripheral requests for interrupts 3..15 |
| gie | input | 1 | Global interrupt enable flag |
| swi_valid | input | 1 | Software-interrupt instruction in execute |
| swi_num | input | 4 | Handler number of the software interrupt |
| reti | input | 1 | Return-from-interrupt instruction in execute |
| unit_busy | input | 1 | Some other unit is busy |
| ex_valid | input | 1 | Execute stage holds a valid instruction |
| pc_cur | input | 16 | Address of the instruction in execute |
| pc_next | input | 16 | Address of the instruction after it |
| flags_in | input | 16 | Current flag word of the core |
| vec_we | input | 1 | Write handler entry |
| vec_idx | input | 4 | Handler entry index for read and write |
| vec_wdata | input | 16 | Handler address to write |
| ira_we | input | 1 | Direct write of the return address |
| shfl_we | input | 1 | Direct write of the shadow flags |
| sys_wdata | input | 16 | Data for the direct writes |
| vec_rdata | output | 16 | Handler entry at `vec_idx` |
| redirect | output | 1 | Flush and load `redirect_pc` |
| redirect_pc | output | 16 | New program counter |
| flag_save | output | 1 | Entry: save flags, clear enable |
| flag_restore | output | 1 | Return: reload flags from `shfl_q` |
| taken_num | output | 4 | Number of the interrupt entered |
| ira_q | output | 16 | Saved return address |
| shfl_q | output | 16 | Shadow flag word |

## Verification
The hardest situations to reach are collisions within one eligible cycle:
- a trap, several peripheral lines and a software interrupt all present together;
- a return arriving while a peripheral line is high;
- a handler write to the very entry being taken;
- a direct register write on the cycle of an entry.

Directed sequences set up each collision on purpose, with `gie`, `unit_busy` and `ex_valid` switched around it. A long run with sparse random requests then mixes them further. A behavioural model recomputes every output on every cycle.

// File: rtl/irq_pkg.sv
// Shared constants and types of the interrupt unit.
// Assumes a 16-bit datapath and sixteen handler numbers.
package irq_pkg;
    localparam int WORD_W    = 16;
    localparam int VEC_COUNT = 16;
    localparam int TRAP_COUNT = 3;

    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_ENTER  = 2'd1,
        ACT_RETURN = 2'd2
    } irq_act_e;
endpackage

// File: rtl/irq_vec_file.sv
// Handler address file: one write port, two combinational read ports.
// Assumes the write index is always within range (power-of-two depth).
module irq_vec_file #(
    parameter int DW = 16,
    parameter int NV = 16,
    localparam int IW = $clog2(NV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx_a,
    input  logic [IW-1:0] ridx_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem [NV];

    // Storage update: clear on reset, single-entry write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NV; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Read ports see the value before any write of the same cycle.
    assign rdata_a = mem[ridx_a];
    assign rdata_b = mem[ridx_b];

    AST_VEC_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(widx)] == $past(wdata)); // R2
endmodule

// File: rtl/irq_pick.sv
// Request arbiter: lowest-numbered hardware request first, software last.
// Assumes trap lines occupy the lowest numbers and devices the rest.
module irq_pick #(
    parameter int NV = 16,
    parameter int NT = 3,
    localparam int IW = $clog2(NV),
    localparam int ND = NV - NT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] trap_req,
    input  logic [ND-1:0] dev_req,
    input  logic          gie,
    input  logic          swi_valid,
    input  logic [IW-1:0] swi_num,
    output logic          hit,
    output logic [IW-1:0] num,
    output logic          resume_same
);
    logic [NV-1:0] req;
    logic [NV-1:0] grant;

    // Request vector: traps unconditionally, devices only when enabled.
    for (genvar k = 0; k < NV; k++) begin : g_req
        if (k < NT) begin : g_trap
            assign req[k] = trap_req[k];
        end else begin : g_dev
            assign req[k] = dev_req[k-NT] & gie;
        end
    end

    // Priority scan: keep only the lowest set request.
    always_comb begin
        grant = '0;
        for (int k = NV - 1; k >= 0; k--) begin
            if (req[k]) grant = NV'(1) << k;
        end
    end

    // Encode the winner, falling back to the software request.
    always_comb begin
        hit         = 1'b0;
        num         = '0;
        resume_same = 1'b0;
        for (int k = 0; k < NV; k++) begin
            if (grant[k]) begin
                hit         = 1'b1;
                num         = IW'(k);
                resume_same = (k >= NT);
            end
        end
        if (!hit && swi_valid) begin
            hit = 1'b1;
            num = swi_num;
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R5
endmodule

// File: rtl/irq_ctx.sv
// Saved context: return address and shadow flag registers.
// Assumes entry capture outranks the direct system writes.
module irq_ctx #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enter,
    input  logic [DW-1:0] ret_addr,
    input  logic [DW-1:0] flags_in,
    input  logic          ira_we,
    input  logic          shfl_we,
    input  logic [DW-1:0] sys_wdata,
    output logic [DW-1:0] ira_q,
    output logic [DW-1:0] shfl_q
);
    // Return address: captured on entry, else direct write.
    always_ff @(posedge clk) begin
        if (!rst_n)      ira_q <= '0;
        else if (enter)  ira_q <= ret_addr;
        else if (ira_we) ira_q <= sys_wdata;
    end

    // Shadow flags: captured on entry, else direct write.
    always_ff @(posedge clk) begin
        if (!rst_n)       shfl_q <= '0;
        else if (enter)   shfl_q <= flags_in;
        else if (shfl_we) shfl_q <= sys_wdata;
    end

    AST_DIRECT_IRA: assert property (@(posedge clk) disable iff (!rst_n)
        (ira_we && !enter) |=> ira_q == $past(sys_wdata)); // R10
endmodule

// File: rtl/irq_unit.sv
// Interrupt unit top: gates entry on an idle, valid execute stage,
// chooses between entry and return, and drives the redirect.
// Assumes the core clears its enable flag on flag_save and reloads
// flags from shfl_q on flag_restore.
module irq_unit #(
    parameter int DW = irq_pkg::WORD_W,
    parameter int NV = irq_pkg::VEC_COUNT,
    parameter int NT = irq_pkg::TRAP_COUNT,
    localparam int IW = $clog2(NV),
    localparam int ND = NV - NT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] trap_req,
    input  logic [ND-1:0] dev_req,
    input  logic          gie,
    input  logic          swi_valid,
    input  logic [IW-1:0] swi_num,
    input  logic          reti,
    input  logic          unit_busy,
    input  logic          ex_valid,
    input  logic [DW-1:0] pc_cur,
    input  logic [DW-1:0] pc_next,
    input  logic [DW-1:0] flags_in,
    input  logic          vec_we,
    input  logic [IW-1:0] vec_idx,
    input  logic [DW-1:0] vec_wdata,
    input  logic          ira_we,
    input  logic          shfl_we,
    input  logic [DW-1:0] sys_wdata,
    output logic [DW-1:0] vec_rdata,
    output logic          redirect,
    output logic [DW-1:0] redirect_pc,
    output logic          flag_save,
    output logic          flag_restore,
    output logic [IW-1:0] taken_num,
    output logic [DW-1:0] ira_q,
    output logic [DW-1:0] shfl_q
);
    import irq_pkg::*;

    logic          eligible;
    logic          pick_hit;
    logic [IW-1:0] pick_num;
    logic          pick_same;
    logic [DW-1:0] handler_pc;
    logic [DW-1:0] ret_addr;
    irq_act_e      act;

    // Eligibility: out of reset, valid instruction, nothing busy.
    assign eligible = rst_n && ex_valid && !unit_busy;

    irq_pick #(.NV(NV), .NT(NT)) u_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .trap_req    (trap_req),
        .dev_req     (dev_req),
        .gie         (gie),
        .swi_valid   (swi_valid),
        .swi_num     (swi_num),
        .hit         (pick_hit),
        .num         (pick_num),
        .resume_same (pick_same)
    );

    irq_vec_file #(.DW(DW), .NV(NV)) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (vec_we),
        .widx    (vec_idx),
        .wdata   (vec_wdata),
        .ridx_a  (vec_idx),
        .ridx_b  (pick_num),
        .rdata_a (vec_rdata),
        .rdata_b (handler_pc)
    );

    // Action select: entry outranks return; neither without eligibility.
    always_comb begin
        if (eligible && pick_hit)  act = ACT_ENTER;
        else if (eligible && reti) act = ACT_RETURN;
        else                       act = ACT_IDLE;
    end

    // Peripherals re-run the interrupted instruction; the rest resume after it.
    assign ret_addr = pick_same ? pc_cur : pc_next;

    irq_ctx #(.DW(DW)) u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .enter     (act == ACT_ENTER),
        .ret_addr  (ret_addr),
        .flags_in  (flags_in),
        .ira_we    (ira_we),
        .shfl_we   (shfl_we),
        .sys_wdata (sys_wdata),
        .ira_q     (ira_q),
        .shfl_q    (shfl_q)
    );

    // Output decode of the chosen action.
    always_comb begin
        redirect     = 1'b0;
        redirect_pc  = '0;
        flag_save    = 1'b0;
        flag_restore = 1'b0;
        taken_num    = '0;
        case (act)
            ACT_ENTER: begin
                redirect    = 1'b1;
                redirect_pc = handler_pc;
                flag_save   = 1'b1;
                taken_num   = pick_num;
            end
            ACT_RETURN: begin
                redirect     = 1'b1;
                redirect_pc  = ira_q;
                flag_restore = 1'b1;
            end
            default: ;
        endcase
    end

    AST_GATE_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (ex_valid && !unit_busy)); // R3
    AST_DEV_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_save && !gie && !swi_valid) |-> (int'(taken_num) < NT)); // R4
    AST_IRA_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_save && int'(taken_num) >= NT && !swi_valid) |=> ira_q == $past(pc_cur)); // R7
    AST_IRA_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_save && int'(taken_num) < NT) |=> ira_q == $past(pc_next)); // R7
    AST_SHADOW_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_save |=> shfl_q == $past(flags_in)); // R8
    AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        flag_restore |-> (!flag_save && reti && redirect_pc == ira_q)); // R9
endmodule

// File: tb/sim_irq_unit.sv
// Bench for irq_unit: behavioural reference model compared every cycle.
module sim_irq_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  trap_req;
    logic [12:0] dev_req;
    logic        gie, swi_valid, reti, unit_busy, ex_valid;
    logic [3:0]  swi_num, vec_idx;
    logic [15:0] pc_cur, pc_next, flags_in, vec_wdata, sys_wdata;
    logic        vec_we, ira_we, shfl_we;
    logic [15:0] vec_rdata, redirect_pc, ira_q, shfl_q;
    logic        redirect, flag_save, flag_restore;
    logic [3:0]  taken_num;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .dev_req(dev_req),
        .gie(gie), .swi_valid(swi_valid), .swi_num(swi_num), .reti(reti),
        .unit_busy(unit_busy), .ex_valid(ex_valid), .pc_cur(pc_cur),
        .pc_next(pc_next), .flags_in(flags_in), .vec_we(vec_we),
        .vec_idx(vec_idx), .vec_wdata(vec_wdata), .ira_we(ira_we),
        .shfl_we(shfl_we), .sys_wdata(sys_wdata), .vec_rdata(vec_rdata),
        .redirect(redirect), .redirect_pc(redirect_pc), .flag_save(flag_save),
        .flag_restore(flag_restore), .taken_num(taken_num), .ira_q(ira_q),
        .shfl_q(shfl_q)
    );

    int n_checks = 0;
    int n_bad = 0;
    string scen = "reset";

    // Reference state
    int m_vec [16];
    int m_ira, m_shfl;
    // Reference outputs of the current cycle
    int e_redir, e_pc, e_save, e_rest, e_num, e_ret, e_enter;

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", tag, scen, act, exp);
        end
    endtask

    // Model: work out this cycle's action from the requirements.
    task automatic model_eval();
        int win;
        bit elig;
        win = -1;
        elig = rst_n && ex_valid && !unit_busy;                 // R3
        for (int k = 15; k >= 0; k--) begin                      // R5 lowest wins
            if (k < 3 ? trap_req[k] : (dev_req[k-3] && gie)) win = k;  // R4
        end
        e_redir = 0; e_pc = 0; e_save = 0; e_rest = 0; e_num = 0; e_enter = 0; e_ret = 0;
        if (elig && win >= 0) begin
            e_enter = 1; e_num = win;
            e_ret = (win >= 3) ? int'(pc_cur) : int'(pc_next);  // R7
        end else if (elig && swi_valid) begin
            e_enter = 1; e_num = swi_num; e_ret = pc_next;
        end
        if (e_enter) begin
            e_redir = 1; e_save = 1; e_pc = m_vec[e_num];        // R6
        end else if (elig && reti) begin
            e_redir = 1; e_rest = 1; e_pc = m_ira;               // R9
        end
    endtask

    task automatic model_update();
        if (!rst_n) begin
            foreach (m_vec[i]) m_vec[i] = 0;
            m_ira = 0; m_shfl = 0;
        end else begin
            if (vec_we) m_vec[vec_idx] = vec_wdata;
            if (e_enter) begin m_ira = e_ret; m_shfl = flags_in; end  // R8
            else begin                                                 // R10
                if (ira_we)  m_ira  = sys_wdata;
                if (shfl_we) m_shfl = sys_wdata;
            end
        end
    endtask

    // One cycle: inputs are set at the falling edge; compare, then advance.
    task automatic cyc();
        #1;
        model_eval();
        if (!rst_n) begin
            chk("R1", redirect, 0);
            chk("R1", flag_save, 0);
            chk("R1", flag_restore, 0);
        end else begin
            chk("R6", redirect, e_redir);
            chk("R6", flag_save, e_save);
            chk("R6", redirect_pc, e_pc);
            chk("R6", taken_num, e_num);
            chk("R9", flag_restore, e_rest);
            chk("R7", ira_q, m_ira);
            chk("R8", shfl_q, m_shfl);
            chk("R2", vec_rdata, m_vec[vec_idx]);
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic quiet();
        trap_req = 0; dev_req = 0; swi_valid = 0; reti = 0; vec_we = 0;
        ira_we = 0; shfl_we = 0; unit_busy = 0; ex_valid = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; gie = 0; swi_num = 0; vec_idx = 0; vec_wdata = 0;
        pc_cur = 16'h0100; pc_next = 16'h0102; flags_in = 16'h0010; sys_wdata = 0;
        quiet();
        foreach (m_vec[i]) m_vec[i] = 0;
        m_ira = 0; m_shfl = 0;
        @(negedge clk);
        // R1: requests present during reset must not act
        trap_req = 3'b111; dev_req = '1; gie = 1;
        repeat (3) cyc();
        rst_n = 1; quiet();
        scen = "R1 state after reset";
        for (int i = 0; i < 16; i++) begin vec_idx = 4'(i); cyc(); end
        chk("R1", ira_q, 0);
        chk("R1", shfl_q, 0);

        scen = "R2 fill handlers";
        for (int i = 0; i < 16; i++) begin
            vec_we = 1; vec_idx = 4'(i); vec_wdata = 16'(16'h1000 + i * 16'h0111);
            cyc();
        end
        vec_we = 0;
        for (int i = 0; i < 16; i++) begin vec_idx = 4'(i); cyc(); end

        scen = "R4 device blocked by gie";
        gie = 0; dev_req = 13'h0004; cyc();
        chk("R4", redirect, 0);
        scen = "R3 busy blocks";
        gie = 1; unit_busy = 1; cyc();
        chk("R3", redirect, 0);
        scen = "R3 invalid ex blocks";
        unit_busy = 0; ex_valid = 0; cyc();
        chk("R3", redirect, 0);
        scen = "R6 device 5 entry";
        ex_valid = 1; pc_cur = 16'h0200; pc_next = 16'h0202; flags_in = 16'h0033;
        cyc();
        chk("R7", ira_q, 16'h0200);
        dev_req = 0;

        scen = "R5 trap beats devices and swi";
        dev_req = 13'h0041; trap_req = 3'b010; swi_valid = 1; swi_num = 4'd9;
        pc_cur = 16'h0300; pc_next = 16'h0302; cyc();
        chk("R7", ira_q, 16'h0302);
        scen = "R5 lowest device wins";
        trap_req = 0; cyc();
        scen = "R4 traps ignore gie";
        gie = 0; dev_req = 0; trap_req = 3'b100; cyc();
        trap_req = 3'b001; cyc();
        scen = "R5 swi without gie";
        trap_req = 0; swi_num = 4'd7; flags_in = 16'h0055; cyc();

        scen = "R9 return";
        swi_valid = 0; reti = 1; cyc();
        scen = "R9 entry beats return";
        gie = 1; dev_req = 13'h1000; cyc();
        scen = "R9 return blocked by busy";
        dev_req = 0; unit_busy = 1; cyc();
        unit_busy = 0; reti = 0;

        scen = "R10 direct writes";
        ira_we = 1; shfl_we = 1; sys_wdata = 16'hBEEF; cyc();
        ira_we = 0; shfl_we = 0; cyc();
        chk("R10", ira_q, 16'hBEEF);
        scen = "R10 entry overrides direct write";
        ira_we = 1; shfl_we = 1; sys_wdata = 16'h1234; trap_req = 3'b001;
        pc_next = 16'h0404; flags_in = 16'h00A0; cyc();
        trap_req = 0; ira_we = 0; shfl_we = 0; cyc();
        chk("R10", ira_q, 16'h0404);

        scen = "R6 write to taken entry same cycle";
        vec_we = 1; vec_idx = 4'd4; vec_wdata = 16'h7777; dev_req = 13'h0002; cyc();
        vec_we = 0; cyc();
        chk("R6", redirect_pc, 16'h7777);

        scen = "R11 level held retakes";
        dev_req = 13'h0100; repeat (3) cyc();
        scen = "R11 dropped line leaves nothing";
        ex_valid = 0; cyc();
        dev_req = 0; ex_valid = 1; cyc();
        chk("R11", redirect, 0);

        scen = "random mix";
        for (int n = 0; n < 600; n++) begin
            ex_valid  = ($urandom_range(0, 3) != 0);
            unit_busy = ($urandom_range(0, 3) == 0);
            gie       = 1'($urandom);
            trap_req  = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b0;
            dev_req   = ($urandom_range(0, 2) == 0) ? 13'(1 << $urandom_range(0, 12)) : 13'b0;
            swi_valid = ($urandom_range(0, 5) == 0);
            swi_num   = 4'($urandom);
            reti      = ($urandom_range(0, 4) == 0);
            vec_we    = ($urandom_range(0, 4) == 0);
            vec_idx   = 4'($urandom);
            vec_wdata = 16'($urandom);
            ira_we    = ($urandom_range(0, 6) == 0);
            shfl_we   = ($urandom_range(0, 6) == 0);
            sys_wdata = 16'($urandom);
            pc_cur    = 16'($urandom) & 16'hFFFE;
            pc_next   = pc_cur + 16'd2;
            flags_in  = 16'($urandom) & 16'h003F;
            cyc();
        end

        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule